// File: doc/BRIEF.md
# Memory-Reference Execute Stage

This block carries out the execute phase of the seven memory-reference operations of a single-accumulator machine. The surrounding control hands it an operation, an effective address that has already been resolved, and the current accumulator, carry flag and program counter. The block then steps through up to three micro-operation steps. These are the timing slots T4, T5 and T6 of the instruction cycle. In each step it reads or writes one memory word over a shared address/data path and updates its accumulator (AC), carry (E), data (DR), program counter (PC) and address (AR) registers. When it reaches the final step of the operation it clears its step counter and raises `done`. The updated state is then presented on its outputs.

The supported operations are bitwise AND, add with carry-out, load, store, unconditional jump, subroutine call and increment-and-skip-if-zero. For a subroutine call, the return address is kept in the target word and execution resumes at the word after it. Increment-and-skip-if-zero serves as a loop counter held in memory.

Work enters through a valid/ready handshake. `in_ready` is high whenever the block is idle. An operation is taken on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` then stays low until the operation has finished. The result side has no back-pressure. `done` is a one-cycle pulse, and the register outputs hold their values until the next operation is accepted. Memory is expected to return `mem_rdata` combinationally for `mem_addr` within the same cycle.

Top module: `mri_exec`

## Requirements
- R1: After reset `in_ready` is 1, `done` is 0 and AC, E, PC, AR and DR are 0. On an accepting edge AR, AC, E and PC are loaded from `in_ea`, `in_ac`, `in_e` and `in_pc`. `in_ready` is low while work is in progress. `done` is high for exactly one cycle, the cycle after the edge of the final step, and in that cycle `in_ready` is already 1. While the block is idle its register outputs do not change.
- R2: `in_op` encoding: 0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ. Value 7 finishes after one step with no memory access and no register change.
- R3: AND (op 0) sets AC to AC & M[EA], leaves E unchanged, and takes two steps.
- R4: ADD (op 1) sets AC to the low DW bits of AC + M[EA] and E to the carry-out, and takes two steps.
- R5: LDA (op 2) sets AC to M[EA], leaves E unchanged, and takes two steps.
- R6: STA (op 3) writes AC to M[EA] in a single step and leaves AC unchanged.
- R7: BUN (op 4) sets PC to EA in a single step and writes no memory.
- R8: BSA (op 5) writes PC, zero-extended, to M[EA]. It ends with AR and PC both equal to EA+1 modulo 2^AW, and takes two steps.
- R9: ISZ (op 6) writes M[EA]+1 modulo 2^DW back to M[EA] and leaves it in DR. It increments PC modulo 2^AW only when that new value is 0, and takes three steps.
- R10: `mem_rd` and `mem_we` are never high together, both are low while idle, and `mem_addr` always equals AR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | Block is idle and will take an operation |
| in_op | input | 3 | Operation code (see R2) |
| in_ea | input | AW | Effective address |
| in_ac | input | DW | Accumulator value at start |
| in_e | input | 1 | Carry flag at start |
| in_pc | input | AW | Address of the next instruction |
| mem_addr | output | AW | Memory word address (AR) |
| mem_rd | output | 1 | Memory word is read into the block this step |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data for `mem_addr` |
| done | output | 1 | One-cycle pulse: operation finished |
| ac_o | output | DW | Accumulator |
| e_o | output | 1 | Carry flag |
| pc_o | output | AW | Program counter |
| ar_o | output | AW | Address register |
| dr_o | output | DW | Data register |

## Verification
The bench builds the block with AW = 6 and DW = 8, which gives a 64-word memory and 8-bit data words. With these narrow widths the carry-out of ADD is easy to produce, the ISZ counter reaches zero from 0xFF in a single step, and BSA and the ISZ skip can both be driven across the top address so that PC and AR wrap to zero. Each operation is checked for its result values and for its step count, measured from the accepting edge to the `done` pulse.

// File: rtl/mri_pkg.sv
package mri_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_ADD  = 3'd1,
    OP_LDA  = 3'd2,
    OP_STA  = 3'd3,
    OP_BUN  = 3'd4,
    OP_BSA  = 3'd5,
    OP_ISZ  = 3'd6,
    OP_NONE = 3'd7
  } mri_op_e;

  localparam int OP_W     = 3;
  localparam int NUM_OPS  = 1 << OP_W;
  // Execute slots T4..T6 map onto step indices 0..2.
  localparam int FIRST_T  = 4;
  localparam int NUM_STEP = 3;
endpackage

// File: rtl/mri_decode.sv
module mri_decode
  import mri_pkg::*;
(
  input  logic [OP_W-1:0]    op,
  output logic [NUM_OPS-1:0] d_line
);
  for (genvar i = 0; i < NUM_OPS; i++) begin : g_line
    assign d_line[i] = (op == OP_W'(i));
  end
endmodule

// File: rtl/mri_timing.sv
module mri_timing #(
  parameter int NSTEP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clear,
  output logic             busy,
  output logic [NSTEP-1:0] t_step
);
  localparam int SW = (NSTEP > 1) ? $clog2(NSTEP) : 1;

  logic [SW-1:0] sc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc   <= '0;
      busy <= 1'b0;
    end else if (start) begin
      sc   <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      if (clear) begin
        sc   <= '0;
        busy <= 1'b0;
      end else begin
        sc <= sc + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NSTEP; i++) begin : g_step
    assign t_step[i] = busy && (sc == SW'(i));
  end
endmodule

// File: rtl/mri_alu.sv
module mri_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] ac,
  input  logic [DW-1:0] dr,
  output logic [DW-1:0] and_res,
  output logic [DW-1:0] sum_res,
  output logic          carry,
  output logic [DW-1:0] dr_inc
);
  logic [DW:0] wide_sum;

  always_comb begin
    and_res  = ac & dr;
    wide_sum = {1'b0, ac} + {1'b0, dr};
    sum_res  = wide_sum[DW-1:0];
    carry    = wide_sum[DW];
    dr_inc   = dr + 1'b1;
  end
endmodule

// File: rtl/mri_exec.sv
module mri_exec
  import mri_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_op,
  input  logic [AW-1:0]   in_ea,
  input  logic [DW-1:0]   in_ac,
  input  logic            in_e,
  input  logic [AW-1:0]   in_pc,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rd,
  output logic            mem_we,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            done,
  output logic [DW-1:0]   ac_o,
  output logic            e_o,
  output logic [AW-1:0]   pc_o,
  output logic [AW-1:0]   ar_o,
  output logic [DW-1:0]   dr_o
);
  logic [DW-1:0]       ac_q, dr_q;
  logic                e_q;
  logic [AW-1:0]       pc_q, ar_q;
  logic [OP_W-1:0]     op_q;
  logic [NUM_OPS-1:0]  d;
  logic [NUM_STEP-1:0] t;
  logic                busy, start, last;
  logic [DW-1:0]       and_res, sum_res, dr_inc, pc_ext;
  logic                carry;
  logic                t4, t5, t6;

  assign start    = in_valid && in_ready;
  assign in_ready = !busy;

  mri_decode u_dec (.op(op_q), .d_line(d));

  mri_timing #(.NSTEP(NUM_STEP)) u_tim (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(last),
    .busy(busy), .t_step(t)
  );

  mri_alu #(.DW(DW)) u_alu (
    .ac(ac_q), .dr(dr_q), .and_res(and_res), .sum_res(sum_res),
    .carry(carry), .dr_inc(dr_inc)
  );

  assign t4 = t[0];
  assign t5 = t[1];
  assign t6 = t[2];

  always_comb begin
    pc_ext = '0;
    pc_ext[AW-1:0] = pc_q;
  end

  // Step control: which micro-operations fire in this slot.
  always_comb begin
    mem_rd = t4 && (d[OP_AND] || d[OP_ADD] || d[OP_LDA] || d[OP_ISZ]);
    mem_we = (t4 && (d[OP_STA] || d[OP_BSA])) || (t6 && d[OP_ISZ]);
    if (d[OP_STA])      mem_wdata = ac_q;
    else if (d[OP_BSA]) mem_wdata = pc_ext;
    else                mem_wdata = dr_q;
    last = (t4 && (d[OP_STA] || d[OP_BUN] || d[OP_NONE])) ||
           (t5 && (d[OP_AND] || d[OP_ADD] || d[OP_LDA] || d[OP_BSA])) ||
           (t6 && d[OP_ISZ]);
  end

  assign mem_addr = ar_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q <= '0;
      e_q  <= 1'b0;
      pc_q <= '0;
      ar_q <= '0;
      dr_q <= '0;
      op_q <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (start) begin
        ar_q <= in_ea;
        ac_q <= in_ac;
        e_q  <= in_e;
        pc_q <= in_pc;
        op_q <= in_op;
      end else begin
        if (mem_rd) dr_q <= mem_rdata;
        if (t4 && d[OP_BUN]) pc_q <= ar_q;
        if (t4 && d[OP_BSA]) ar_q <= ar_q + 1'b1;
        if (t5 && d[OP_AND]) ac_q <= and_res;
        if (t5 && d[OP_ADD]) begin
          ac_q <= sum_res;
          e_q  <= carry;
        end
        if (t5 && d[OP_LDA]) ac_q <= dr_q;
        if (t5 && d[OP_BSA]) pc_q <= ar_q;
        if (t5 && d[OP_ISZ]) dr_q <= dr_inc;
        if (t6 && d[OP_ISZ] && (dr_q == '0)) pc_q <= pc_q + 1'b1;
      end
    end
  end

  assign ac_o = ac_q;
  assign e_o  = e_q;
  assign pc_o = pc_q;
  assign ar_o = ar_q;
  assign dr_o = dr_q;
endmodule

// File: rtl/mri_exec_chk.sv
module mri_exec_chk #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          mem_rd,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] ar_o,
  input logic          done,
  input logic [DW-1:0] ac_o
);
  logic [1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_cnt <= '0;
    else if (in_ready)  busy_cnt <= '0;
    else if (busy_cnt != 2'd3) busy_cnt <= busy_cnt + 1'b1;
  end

  a_r10_rd_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!mem_rd && !mem_we));

  a_r10_addr_is_ar: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr == ar_o);

  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  a_r1_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (busy_cnt < 2'd3));

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(ac_o));
endmodule

bind mri_exec mri_exec_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr), .ar_o(ar_o),
  .done(done), .ac_o(ac_o)
);

// File: tb/test_mri_exec.sv
`timescale 1ns/1ps
module test_mri_exec;
  localparam int AW = 6;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_op = '0;
  logic [AW-1:0] in_ea = '0;
  logic [DW-1:0] in_ac = '0;
  logic          in_e = 1'b0;
  logic [AW-1:0] in_pc = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_we;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          done;
  logic [DW-1:0] ac_o, dr_o;
  logic          e_o;
  logic [AW-1:0] pc_o, ar_o;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  bit finished = 0;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic          pre_en = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [DW-1:0] pre_data = '0;

  always #2 clk = ~clk;

  mri_exec #(.AW(AW), .DW(DW)) i_mri_exec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_ea(in_ea), .in_ac(in_ac), .in_e(in_e), .in_pc(in_pc),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
    .ac_o(ac_o), .e_o(e_o), .pc_o(pc_o), .ar_o(ar_o), .dr_o(dr_o)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (pre_en) mem[pre_addr] <= pre_data;
    else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R10 port monitor
  always @(negedge clk) begin
    if (rst_n && ((mem_rd && mem_we) || (in_ready && (mem_rd || mem_we)) || (mem_addr !== ar_o))) begin
      errors++;
      $display("FAIL R10: actual rd=%0b we=%0b ready=%0b expected exclusive and quiet when idle",
               mem_rd, mem_we, in_ready);
    end
  end

  task automatic preload(input logic [AW-1:0] a, input logic [DW-1:0] v);
    @(negedge clk);
    pre_en = 1'b1; pre_addr = a; pre_data = v;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] ea,
                        input logic [DW-1:0] ac, input logic e,
                        input logic [AW-1:0] pc, output int lat);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_ea = ea; in_ac = ac; in_e = e; in_pc = pc;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    check("R1 busy after accept", {31'b0, in_ready}, 32'd0);
    while (!done && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    check("R1 ready with done", {31'b0, in_ready}, 32'd1);
  endtask

  task automatic t_reset();
    check("R1 reset ready", {31'b0, in_ready}, 32'd1);
    check("R1 reset done", {31'b0, done}, 32'd0);
    check("R1 reset ac", {24'b0, ac_o}, 32'd0);
    check("R1 reset pc", {26'b0, pc_o}, 32'd0);
  endtask

  task automatic t_and();
    int lat;
    preload(6'd10, 8'hCA);
    run_op(3'd0, 6'd10, 8'h5F, 1'b1, 6'd3, lat);
    check("R3 and latency", lat, 2);
    check("R3 and result", {24'b0, ac_o}, {24'b0, 8'hCA & 8'h5F});
    check("R3 and keeps E", {31'b0, e_o}, 32'd1);
  endtask

  task automatic t_add();
    int lat;
    preload(6'd11, 8'h34);
    run_op(3'd1, 6'd11, 8'h12, 1'b1, 6'd3, lat);
    check("R4 add latency", lat, 2);
    check("R4 add sum", {24'b0, ac_o}, 32'h46);
    check("R4 add no carry", {31'b0, e_o}, 32'd0);
    preload(6'd12, 8'h20);
    run_op(3'd1, 6'd12, 8'hF0, 1'b0, 6'd3, lat);
    check("R4 add wrap sum", {24'b0, ac_o}, 32'h10);
    check("R4 add carry", {31'b0, e_o}, 32'd1);
  endtask

  task automatic t_lda();
    int lat;
    preload(6'd5, 8'h99);
    run_op(3'd2, 6'd5, 8'h01, 1'b1, 6'd3, lat);
    check("R5 lda latency", lat, 2);
    check("R5 lda value", {24'b0, ac_o}, 32'h99);
    check("R5 lda keeps E", {31'b0, e_o}, 32'd1);
  endtask

  task automatic t_sta();
    int lat;
    preload(6'd20, 8'h00);
    run_op(3'd3, 6'd20, 8'h3C, 1'b0, 6'd3, lat);
    check("R6 sta latency", lat, 1);
    check("R6 sta memory", {24'b0, mem[20]}, 32'h3C);
    check("R6 sta keeps ac", {24'b0, ac_o}, 32'h3C);
  endtask

  task automatic t_bun();
    int lat, w0;
    preload(6'd33, 8'h77);
    w0 = wr_cnt;
    run_op(3'd4, 6'd33, 8'h00, 1'b0, 6'd9, lat);
    check("R7 bun latency", lat, 1);
    check("R7 bun pc", {26'b0, pc_o}, 32'd33);
    check("R7 bun no write", wr_cnt - w0, 0);
  endtask

  task automatic t_bsa();
    int lat;
    run_op(3'd5, 6'd40, 8'h00, 1'b0, 6'd17, lat);
    check("R8 bsa latency", lat, 2);
    check("R8 bsa return word", {24'b0, mem[40]}, 32'd17);
    check("R8 bsa pc", {26'b0, pc_o}, 32'd41);
    check("R8 bsa ar", {26'b0, ar_o}, 32'd41);
    run_op(3'd5, 6'd63, 8'h00, 1'b0, 6'd50, lat);
    check("R8 bsa top word", {24'b0, mem[63]}, 32'd50);
    check("R8 bsa pc wrap", {26'b0, pc_o}, 32'd0);
  endtask

  task automatic t_isz();
    int lat;
    preload(6'd7, 8'h05);
    run_op(3'd6, 6'd7, 8'h00, 1'b0, 6'd12, lat);
    check("R9 isz latency", lat, 3);
    check("R9 isz memory", {24'b0, mem[7]}, 32'h06);
    check("R9 isz dr", {24'b0, dr_o}, 32'h06);
    check("R9 isz no skip", {26'b0, pc_o}, 32'd12);
    preload(6'd8, 8'hFF);
    run_op(3'd6, 6'd8, 8'h00, 1'b0, 6'd12, lat);
    check("R9 isz zero memory", {24'b0, mem[8]}, 32'h00);
    check("R9 isz skip", {26'b0, pc_o}, 32'd13);
    preload(6'd9, 8'hFF);
    run_op(3'd6, 6'd9, 8'h00, 1'b0, 6'd63, lat);
    check("R9 isz skip wrap", {26'b0, pc_o}, 32'd0);
  endtask

  task automatic t_none();
    int lat, w0;
    w0 = wr_cnt;
    run_op(3'd7, 6'd2, 8'hA5, 1'b1, 6'd21, lat);
    check("R2 op7 latency", lat, 1);
    check("R2 op7 ac", {24'b0, ac_o}, 32'hA5);
    check("R2 op7 pc", {26'b0, pc_o}, 32'd21);
    check("R2 op7 no write", wr_cnt - w0, 0);
  endtask

  task automatic t_idle_hold();
    logic [DW-1:0] a0;
    a0 = ac_o;
    repeat (3) @(negedge clk);
    check("R1 idle hold", {24'b0, ac_o}, {24'b0, a0});
    check("R1 done single pulse", {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_and();
    t_add();
    t_lda();
    t_sta();
    t_bun();
    t_bsa();
    t_isz();
    t_none();
    t_idle_hold();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule